// File: doc/BRIEF.md
# Vector Table Row-Window Controller

This block holds the 5-bit configuration word that chooses which rows of two companion lookup tables are live. One table remaps registers and the other supplies predication. Each table has eight rows, and each row carries two 16-bit entries. The word packs two fields. A 3-bit start row sits in the low bits. A 2-bit span code sits in the top two bits and selects 1, 2, 4 or 8 rows (2, 4, 8 or 16 entries). Rows run upward from the start row, and rows past the last one are dropped.

The word is only five bits wide, so a single immediate-form CSR write can set it completely. The code with every bit set is reserved. Writing it turns off the whole vector extension: the off flag rises and both row masks go to zero. Software reads the word back zero-extended to the CSR width. The two masks and the off flag depend only on the stored word, through combinational logic. They show a new value in the cycle after the write edge.

Top module: `vtab_win_ctrl`

## Requirements
- R1: When rst_ni is low, the stored word becomes 5'b11111. In that state `rd_data_o` is 32'h1F, `ext_off_o` is 1 and both masks are 8'h00.
- R2: If `wr_en_i` is high at a rising clock edge, bits 4..0 of `wr_data_i` are stored. If `wr_en_i` is low, the stored word is held. Outputs show the stored word from just after that edge.
- R3: Bits 31..5 of `wr_data_i` have no effect on the stored word or on any output.
- R4: `rd_data_o` carries the stored word in bits 4..0, and bits 31..5 are zero.
- R5: For any word other than 5'b11111, the start row is bits 2..0 and the span code s is bits 4..3. Mask bit r is set exactly when start <= r < start + 2**s.
- R6: Rows at index 8 or above are dropped from the window. For example, start 1 with span code 3 (word 5'h19) gives mask 8'hFE.
- R7: `ext_off_o` is 1 exactly when the stored word is 5'b11111, and in that case both masks are zero.
- R8: `reg_row_en_o` and `pred_row_en_o` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Write data; only bits 4..0 are used |
| rd_data_o | output | 32 | Stored word, zero-extended |
| reg_row_en_o | output | 8 | Row enables for the register-remap table |
| pred_row_en_o | output | 8 | Row enables for the predication table |
| ext_off_o | output | 1 | Extension disabled (reserved code stored) |

## Verification
Two functions can meet in the same cycle: a write strobe, and the readback plus mask decode of the word being replaced. This matters most when the write enters or leaves the reserved code. The bench raises `wr_en_i` and samples all outputs before that edge, expecting the old window. It samples again just after the edge, expecting the new window from its own model. Writes that carry garbage in the upper data bits, and cycles where data changes with the strobe low, are checked the same way.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int unsigned ROWS    = 8;
  localparam int unsigned START_W = $clog2(ROWS);
  localparam int unsigned SPAN_W  = 2;
  localparam int unsigned CFG_W   = START_W + SPAN_W;
  localparam int unsigned CSR_W   = 32;

  typedef struct packed {
    logic [SPAN_W-1:0]  span;
    logic [START_W-1:0] start;
  } cfg_t;

  localparam cfg_t CFG_OFF = '1;
endpackage

// File: rtl/vtab_cfg_reg.sv
module vtab_cfg_reg
  import vtab_pkg::*;
#(
  parameter int unsigned DATA_W = CSR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rd_data_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= CFG_OFF;
    else if (wr_en_i) cfg_q <= cfg_t'(wr_data_i[CFG_W-1:0]);
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = {{(DATA_W-CFG_W){1'b0}}, cfg_q};

  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cfg_q == $past(wr_data_i[CFG_W-1:0]));
  // R2
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_q));
  // R4
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:CFG_W] == '0);
endmodule

// File: rtl/vtab_row_window.sv
module vtab_row_window
  import vtab_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_t            cfg_i,
  output logic [ROWS-1:0] mask_o,
  output logic            off_o
);
  localparam int unsigned END_W = START_W + 2;

  logic [END_W-1:0] span_rows;
  logic [END_W-1:0] win_end;

  assign off_o     = (cfg_i == CFG_OFF);
  assign span_rows = END_W'(1) << cfg_i.span;
  assign win_end   = END_W'(cfg_i.start) + span_rows;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // rows past ROWS-1 never match: clipping is implicit
    assign mask_o[r] = !off_o
                     && (END_W'(r) >= END_W'(cfg_i.start))
                     && (END_W'(r) <  win_end);
  end

  // R7
  off_mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o |-> mask_o == '0);
  // R5
  start_row_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_o |-> mask_o[cfg_i.start]);
  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_o |-> $countones(mask_o) <= (1 << cfg_i.span));
endmodule

// File: rtl/vtab_win_ctrl.sv
module vtab_win_ctrl
  import vtab_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CSR_W-1:0] wr_data_i,
  output logic [CSR_W-1:0] rd_data_o,
  output logic [ROWS-1:0]  reg_row_en_o,
  output logic [ROWS-1:0]  pred_row_en_o,
  output logic             ext_off_o
);
  cfg_t            cfg;
  logic [ROWS-1:0] win_mask;

  vtab_cfg_reg #(.DATA_W(CSR_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .rd_data_o (rd_data_o)
  );

  vtab_row_window u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg),
    .mask_o (win_mask),
    .off_o  (ext_off_o)
  );

  assign reg_row_en_o  = win_mask;
  assign pred_row_en_o = win_mask;

  // R8
  tables_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_row_en_o == pred_row_en_o);
  // R7
  off_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_off_o |-> rd_data_o == 32'h1F);
endmodule

// File: tb/vtab_win_ctrl_tb.sv
module vtab_win_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  reg_row_en_o, pred_row_en_o;
  logic        ext_off_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] model = 5'h1F;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vtab_win_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .reg_row_en_o(reg_row_en_o),
    .pred_row_en_o(pred_row_en_o), .ext_off_o(ext_off_o)
  );

  function automatic logic [7:0] exp_mask(input logic [4:0] w);
    logic [7:0] m = '0;
    int st = int'(w[2:0]);
    int n  = 1 << w[4:3];
    if (w == 5'h1F) return '0;
    for (int r = 0; r < 8; r++) if (r >= st && r < st + n) m[r] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, "/R4 rd"}, rd_data_o, {27'd0, model});
    chk({req, "/R5 R6 reg"}, {24'd0, reg_row_en_o}, {24'd0, exp_mask(model)});
    chk({req, "/R8 pred"}, {24'd0, pred_row_en_o}, {24'd0, reg_row_en_o});
    chk({req, "/R7 off"}, {31'd0, ext_off_o}, {31'd0, model == 5'h1F});
  endtask

  // drive at negedge, check old value before edge and new value after
  task automatic wr(input logic [31:0] d, input logic en, input string req);
    @(negedge clk_i);
    wr_en_i = en; wr_data_i = d;
    #1 chk_all({req, " pre"});
    @(posedge clk_i);
    if (en) model = d[4:0];
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk_all({req, " post"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 3);
    chk_all("R1 reset");
    chk("R1 off", {31'd0, ext_off_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1 after release");

    wr(32'h0000_0018, 1'b1, "R5 all rows");
    chk("R5 0x18", {24'd0, reg_row_en_o}, 32'hFF);
    wr(32'h0000_0019, 1'b1, "R6 clip 1..7");
    chk("R6 0x19", {24'd0, reg_row_en_o}, 32'hFE);
    wr(32'h0000_0003, 1'b1, "R5 single row3");
    chk("R5 0x03", {24'd0, reg_row_en_o}, 32'h08);
    wr(32'h0000_000F, 1'b1, "R6 start7 span1");
    chk("R6 0x0F", {24'd0, reg_row_en_o}, 32'h80);
    wr(32'h0000_001F, 1'b1, "R7 reserved");
    chk("R7 0x1F", {31'd0, ext_off_o}, 32'd1);
    wr(32'hFFFF_FFE5, 1'b1, "R3 upper ignored");
    chk("R3 rd", rd_data_o, 32'h05);
    wr(32'h0000_0012, 1'b0, "R2 no strobe hold");
    chk("R2 hold", rd_data_o, 32'h05);
    wr(32'h0000_0017, 1'b1, "R6 start7 span2");

    for (int c = 0; c < 32; c++) wr(32'(c), 1'b1, "R5 sweep");
    for (int i = 0; i < 300; i++) wr($urandom, ($urandom % 4) != 0, "R2 R3 random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule